// File: doc/BRIEF.md
# DPLL Loop Filter

This block is the loop filter of a telecom digital phase-locked loop. On every update strobe the phase detector hands it a signed phase-error sample, and the filter moves its signed frequency-offset word toward that sample by a fixed binary fraction. The offset word drives a digitally controlled oscillator. The filter is first order, and its step is `out += (err - out) >>> k` with an arithmetic shift.

A reference-class input chooses between two bandwidths. The narrow setting (large `k`) is for low-rate references in the 2.048 MHz, 1.544 MHz and 8 kHz class, and it heavily attenuates jitter. The wide setting (`k = 0` by default) is for the 8.192 MHz class, and it copies each error sample straight to the output. Changing the setting never clears the accumulated offset.

A second, slower first-order stage keeps a long-term average of the offset word for use during holdover. This stage uses the selected shift plus a fixed extra. It advances only while the loop reports lock and holdover freeze is not requested. The block exposes the average and a flag that says the average holds a captured value.

Top module: `dpll_loop_filter`

## Requirements
- R1: With the narrow class selected (`wide_sel_i = 0`), each cycle with `upd_i = 1` sets `freq_off_o` on the next clock to `out + ((err - out) >>> K_NARROW)`. The shift is arithmetic, so the result is rounded toward minus infinity. K_NARROW defaults to 12.
- R2: With the wide class selected (`wide_sel_i = 1`) and the default `K_WIDE = 0`, an update makes `freq_off_o` equal the sampled `phase_err_i` on the next clock.
- R3: In a cycle with `upd_i = 0`, `freq_off_o`, `hold_freq_o` and `hold_valid_o` keep their values.
- R4: Switching `wide_sel_i` does not reset the accumulator. The first update after a switch starts from the current `freq_off_o`.
- R5: The offset never overshoots. After an update it lies between its previous value and the sampled error, inclusive. The arithmetic is carried wide enough that it never wraps, and results are clamped to the signed limits of W bits, even for full-scale opposite-sign inputs.
- R6: Once `hold_valid_o` is 1, an update with `lock_i = 1` and `freeze_i = 0` sets `hold_freq_o` to `h + ((out - h) >>> (k + K_HOLD_EXTRA))`. Here `out` is `freq_off_o` before the update, and `k` is the shift of the selected class. K_HOLD_EXTRA defaults to 4.
- R7: The first qualifying update (`upd_i`, `lock_i` and not `freeze_i`) while `hold_valid_o = 0` loads `hold_freq_o` with the pre-update `freq_off_o` and sets `hold_valid_o`. The flag stays set until reset.
- R8: An update with `lock_i = 0` or with `freeze_i = 1` leaves `hold_freq_o` and `hold_valid_o` unchanged, while `freq_off_o` still updates.
- R9: A synchronous active-high `rst` clears `freq_off_o` and `hold_freq_o` to 0 and clears `hold_valid_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe: a new phase-error sample is present |
| phase_err_i | input | W | Signed phase-error sample |
| wide_sel_i | input | 1 | 1 = high-rate reference class (wide bandwidth), 0 = low-rate class (narrow) |
| lock_i | input | 1 | Loop is locked; the holdover average may learn |
| freeze_i | input | 1 | Holds the holdover average at its current value |
| freq_off_o | output | W | Signed frequency-offset word to the oscillator |
| hold_freq_o | output | W | Signed long-term average for holdover |
| hold_valid_o | output | 1 | The holdover average holds a captured value |

## Verification
The bench targets full-scale opposite-sign steps. A design that computes the difference in only W bits would wrap, and its offset would jump to the wrong side instead of creeping toward the sample. Small negative differences in narrow mode are checked against floor rounding, which a logical or truncating shift gets wrong by one count. The bench switches bandwidth in the middle of a run, to catch an accumulator that is cleared or reloaded on the switch. It also tests the first lock capture, the freeze and unlock gating, and reset in the middle of a run. An average that learns while frozen, or that starts from zero instead of the current offset, then diverges from the model within one update.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic {
        BW_NARROW = 1'b0,
        BW_WIDE   = 1'b1
    } bw_e;

    typedef struct packed {
        logic en;
        logic load;
    } hold_cmd_t;

    // Clamp a wide signed value to the signed range of w bits.
    function automatic longint clamp_w(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/lf_bw_select.sv
module lf_bw_select
    import lf_pkg::*;
#(
    parameter int K_NARROW     = 12,
    parameter int K_WIDE       = 0,
    parameter int K_HOLD_EXTRA = 4,
    parameter int SHW          = 5
) (
    input  logic           wide_sel_i,
    output logic [SHW-1:0] k_main_o,
    output logic [SHW-1:0] k_hold_o
);
    bw_e bw;

    always_comb begin
        bw       = wide_sel_i ? BW_WIDE : BW_NARROW;
        k_main_o = (bw == BW_WIDE) ? SHW'(K_WIDE) : SHW'(K_NARROW);
        k_hold_o = k_main_o + SHW'(K_HOLD_EXTRA);
    end
endmodule

// File: rtl/lf_ema_stage.sv
module lf_ema_stage
    import lf_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                load,
    input  logic signed [W-1:0] target,
    input  logic [SHW-1:0]      shift,
    output logic signed [W-1:0] y_o
);
    logic signed [W-1:0] y_q;
    logic signed [W:0]   diff;
    logic signed [W:0]   delta;
    logic signed [W+1:0] sum;
    logic signed [W-1:0] y_next;

    always_comb begin
        diff   = {target[W-1], target} - {y_q[W-1], y_q};
        delta  = diff >>> shift;
        sum    = {y_q[W-1], y_q[W-1], y_q} + {delta[W], delta};
        y_next = W'(clamp_w(longint'(sum), W));
    end

    always_ff @(posedge clk) begin
        if (rst)       y_q <= '0;
        else if (load) y_q <= target;
        else if (en)   y_q <= y_next;
    end

    assign y_o = y_q;

    // R5: a filtering step lands between the old value and the target
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=>
            (($signed($past(target)) >= $signed($past(y_q))) ?
                (y_q >= $signed($past(y_q)) && y_q <= $signed($past(target))) :
                (y_q <= $signed($past(y_q)) && y_q >= $signed($past(target)))));

    // R7: a load copies the target exactly
    a_r7_load_copies: assert property (@(posedge clk) disable iff (rst)
        load |=> (y_q == $past(target)));
endmodule

// File: rtl/lf_hold_ctrl.sv
module lf_hold_ctrl
    import lf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd_i,
    input  logic      lock_i,
    input  logic      freeze_i,
    output hold_cmd_t cmd_o,
    output logic      valid_o
);
    logic valid_q;

    always_comb begin
        cmd_o.en   = upd_i && lock_i && !freeze_i;
        cmd_o.load = cmd_o.en && !valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst)            valid_q <= 1'b0;
        else if (cmd_o.en)  valid_q <= 1'b1;
    end

    assign valid_o = valid_q;

    // R7: once captured the flag stays set until reset
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

    // R8: without lock or with freeze the flag does not rise
    a_r8_no_rise_gated: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && (!lock_i || freeze_i || !upd_i)) |=> !valid_q);
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
    import lf_pkg::*;
#(
    parameter int W            = 16,
    parameter int K_NARROW     = 12,
    parameter int K_WIDE       = 0,
    parameter int K_HOLD_EXTRA = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_i,
    input  logic signed [W-1:0] phase_err_i,
    input  logic                wide_sel_i,
    input  logic                lock_i,
    input  logic                freeze_i,
    output logic signed [W-1:0] freq_off_o,
    output logic signed [W-1:0] hold_freq_o,
    output logic                hold_valid_o
);
    localparam int K_MAX = (K_NARROW > K_WIDE) ? K_NARROW : K_WIDE;
    localparam int SH_MAX = K_MAX + K_HOLD_EXTRA;
    localparam int SHW = $clog2(SH_MAX + 1) + 1;

    logic [SHW-1:0]      k_main;
    logic [SHW-1:0]      k_hold;
    hold_cmd_t           hcmd;
    logic signed [W-1:0] off_q;
    logic signed [W-1:0] hold_q;
    logic                valid_q;

    lf_bw_select #(
        .K_NARROW(K_NARROW), .K_WIDE(K_WIDE),
        .K_HOLD_EXTRA(K_HOLD_EXTRA), .SHW(SHW)
    ) u_bw (
        .wide_sel_i(wide_sel_i),
        .k_main_o  (k_main),
        .k_hold_o  (k_hold)
    );

    lf_ema_stage #(.W(W), .SHW(SHW)) u_main (
        .clk   (clk),
        .rst   (rst),
        .en    (upd_i),
        .load  (1'b0),
        .target(phase_err_i),
        .shift (k_main),
        .y_o   (off_q)
    );

    lf_hold_ctrl u_hctl (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (upd_i),
        .lock_i  (lock_i),
        .freeze_i(freeze_i),
        .cmd_o   (hcmd),
        .valid_o (valid_q)
    );

    lf_ema_stage #(.W(W), .SHW(SHW)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .en    (hcmd.en),
        .load  (hcmd.load),
        .target(off_q),
        .shift (k_hold),
        .y_o   (hold_q)
    );

    assign freq_off_o   = off_q;
    assign hold_freq_o  = hold_q;
    assign hold_valid_o = valid_q;

    // R3: no strobe, no movement
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> ($stable(freq_off_o) && $stable(hold_freq_o) && $stable(hold_valid_o)));

    // R8: freeze or loss of lock keeps the average
    a_r8_hold_gated: assert property (@(posedge clk) disable iff (rst)
        (freeze_i || !lock_i) |=> $stable(hold_freq_o));

    // R9: reset clears the outputs
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (freq_off_o == '0 && hold_freq_o == '0 && !hold_valid_o));

    generate
        if (K_WIDE == 0) begin : g_wide_pass
            // R2: wide class copies the error sample
            a_r2_wide_pass: assert property (@(posedge clk) disable iff (rst)
                (upd_i && wide_sel_i) |=> (freq_off_o == $past(phase_err_i)));
        end
    endgenerate
endmodule

// File: tb/sim_dpll_loop_filter.sv
module sim_dpll_loop_filter;
    localparam int W  = 16;
    localparam int KN = 12;
    localparam int KW = 0;
    localparam int KH = 4;
    localparam int HI = 32767;
    localparam int LO = -32768;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0;
    logic signed [W-1:0] err = '0;
    logic wide = 1'b0;
    logic lock = 1'b0;
    logic frz = 1'b0;
    logic signed [W-1:0] off;
    logic signed [W-1:0] hfreq;
    logic hval;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_y = 0;
    int m_h = 0;
    bit m_v = 1'b0;

    always #10 clk = ~clk;

    dpll_loop_filter #(.W(W), .K_NARROW(KN), .K_WIDE(KW), .K_HOLD_EXTRA(KH)) u0 (
        .clk(clk), .rst(rst), .upd_i(upd), .phase_err_i(err),
        .wide_sel_i(wide), .lock_i(lock), .freeze_i(frz),
        .freq_off_o(off), .hold_freq_o(hfreq), .hold_valid_o(hval)
    );

    function automatic int clampi(input int v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "freq_off", int'(off), m_y);
        chk(tag, "hold_freq", int'(hfreq), m_h);
        chk(tag, "hold_valid", int'(hval), int'(m_v));
    endtask

    // Called at a negative edge; applies one cycle and checks it.
    task automatic step(input bit u, input int e, input bit wd, input bit lk,
                        input bit fz, input string tag);
        int k;
        int old_y;
        upd  = u;
        err  = W'(e);
        wide = wd;
        lock = lk;
        frz  = fz;
        @(posedge clk);
        k = wd ? KW : KN;
        old_y = m_y;
        if (u) begin
            m_y = clampi(m_y + ((e - m_y) >>> k));
            if (lk && !fz) begin
                if (!m_v) begin
                    m_h = old_y;
                    m_v = 1'b1;
                end else begin
                    m_h = clampi(m_h + ((old_y - m_h) >>> (k + KH)));
                end
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        upd = 1'b0;
        @(posedge clk);
        m_y = 0;
        m_h = 0;
        m_v = 1'b0;
        @(negedge clk);
        compare_all(tag);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R9");

        // R2: wide pass-through, including full-scale values
        step(1, 1234, 1, 0, 0, "R2");
        step(1, HI, 1, 0, 0, "R2");
        step(1, LO, 1, 0, 0, "R2");
        step(1, -7, 1, 0, 0, "R2");

        // R5: full-scale opposite-sign steps in narrow mode
        step(1, HI, 1, 0, 0, "R2");
        step(1, LO, 0, 0, 0, "R5");
        step(1, LO, 0, 0, 0, "R5");
        step(1, LO, 1, 0, 0, "R2");
        step(1, HI, 0, 0, 0, "R5");

        // R3: idle cycles hold the value
        for (int i = 0; i < 4; i++) step(0, 999, 0, 1, 0, "R3");

        // R1: small negative differences exercise floor rounding
        step(1, 100, 1, 0, 0, "R2");
        step(1, 99, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 40; i++) step(1, -20000 + i * 37, 0, 0, 0, "R1");

        // R4: switch bandwidth mid-run without losing the accumulator
        step(1, 5000, 1, 0, 0, "R4");
        step(1, -3000, 0, 0, 0, "R4");
        step(1, -3000, 0, 0, 0, "R4");
        step(1, 2500, 1, 0, 0, "R4");
        step(1, 2500, 0, 0, 0, "R4");

        // R8: unlocked updates leave the average empty
        for (int i = 0; i < 3; i++) step(1, 4000, 0, 0, 0, "R8");
        step(1, 4000, 0, 1, 1, "R8");

        // R7: first qualifying update captures the current offset
        step(1, 4000, 0, 1, 0, "R7");

        // R6: learning in both bandwidths
        for (int i = 0; i < 30; i++) step(1, 30000, 1, 1, 0, "R6");
        for (int i = 0; i < 30; i++) step(1, -30000, 0, 1, 0, "R6");
        for (int i = 0; i < 20; i++) step(1, LO, 1, 1, 0, "R6");

        // R8: freeze and loss of lock after capture
        for (int i = 0; i < 5; i++) step(1, HI, 1, 1, 1, "R8");
        for (int i = 0; i < 5; i++) step(1, 123, 1, 0, 0, "R8");
        step(0, 0, 1, 1, 0, "R3");

        // Mixed random traffic
        for (int i = 0; i < 200; i++) begin
            step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 65535)) - 32768,
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0),
                 bit'($urandom_range(0, 4) == 0), "R6");
        end

        // R9: reset in the middle of a run
        do_reset("R9");
        step(1, 777, 0, 1, 0, "R7");
        step(1, 777, 0, 1, 0, "R6");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule